// File: doc/BRIEF.md
# Session Key Rotation Controller

This controller decides when the live session key of an encrypted link has to be replaced, and it sequences the changeover. It counts seconds from an external one-second tick and adds up the payload bytes sent under the current key. When the age limit or the volume limit is reached, whichever comes first, it asks an external key-establishment engine for a fresh key. The engine generates, encapsulates and transfers that key, and the peer decapsulates it. The controller then waits until the engine reports that both ends have derived the new key.

When the engine reports ready, the controller flips the key epoch. The cipher path then encrypts with the new slot. The previous slot stays valid for a fixed number of seconds, so that packets tagged with the old epoch can still be handled. When that window ends, the controller pulses a zeroize command for the retired slot. If the engine stays silent for longer than a programmable number of cycles, the controller flags a timeout and requests the key again.

Key slots are identified by the epoch bit. The `slot_valid[e]` output is high while slot `e` may be used.

Top module: `key_rotation_ctrl`

## Requirements
- R1: After reset, epoch is 0 and slot_valid is 2'b01, and rekey_req, timeout_err and zeroize_old are all low.
- R2: In normal operation, when the seconds counted since the last key swap reach TIME_LIMIT_S, rekey_req goes high two cycles after the cycle that carries the final sec_tick.
- R3: Bytes from every cycle with pkt_valid high are added to a byte count. When that count is at least BYTE_LIMIT, rekey_req goes high two cycles after the cycle that carries the packet that crossed the limit.
- R4: A limit condition that arises while a rotation is in progress produces no extra rekey_req. A rotation is in progress from the request until the old key is zeroized. Only the timeout retries of R8 may re-pulse rekey_req in that time.
- R5: rekey_ready high while the controller waits for the engine toggles epoch on the next cycle. From that cycle slot_valid is 2'b11.
- R6: At the key swap, the second and byte counts restart from that cycle's own sec_tick and packet. Both counts then keep running through the overlap window.
- R7: During the overlap, the OVERLAP_S-th sec_tick sets zeroize_old high for that one cycle. From the next cycle, slot_valid holds only the bit of the current epoch.
- R8: While waiting, if ack_timeout cycles pass after a request without rekey_ready, timeout_err is high for one cycle, and rekey_req is high again on the following cycle.
- R9: rekey_ready has no effect when the controller is not waiting for the engine.
- R10: rekey_req is a single-cycle pulse on each request or retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse each second |
| pkt_valid | input | 1 | A packet length is presented this cycle |
| pkt_bytes | input | LEN_W | Bytes in the presented packet |
| ack_timeout | input | TO_W | Cycles to wait for the engine before retrying |
| rekey_ready | input | 1 | Engine reports both sides hold the new key |
| rekey_req | output | 1 | Pulse asking the engine for a new key |
| timeout_err | output | 1 | Pulse when the engine failed to answer in time |
| zeroize_old | output | 1 | Pulse commanding erasure of the slot not selected by epoch |
| epoch | output | 1 | Slot index of the key used for new traffic |
| slot_valid | output | 2 | Per-slot validity, bit index equals slot index |

## Verification
The checker assumes that rekey_ready arrives only as an answer to a request. It also assumes that sec_tick is far sparser than the cycle rate, that ack_timeout is held steady while a request is outstanding, and that pkt_bytes is narrower than the byte counter. The stimulus keeps to these assumptions. It changes ack_timeout only while the controller is in normal operation, it uses small bench limits so that ticks come every few cycles without overlapping engine answers, and it presents rekey_ready outside a request only in the one row that checks that it is ignored.

// File: rtl/key_rotation_ctrl.sv
module key_rotation_ctrl #(
  parameter int          TIME_LIMIT_S = 600,
  parameter int          OVERLAP_S    = 30,
  parameter int          CNT_W        = 32,
  parameter longint      BYTE_LIMIT   = 64'd1073741824,
  parameter int          LEN_W        = 16,
  parameter int          TO_W         = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             pkt_valid,
  input  logic [LEN_W-1:0] pkt_bytes,
  input  logic [TO_W-1:0]  ack_timeout,
  input  logic             rekey_ready,
  output logic             rekey_req,
  output logic             timeout_err,
  output logic             zeroize_old,
  output logic             epoch,
  output logic [1:0]       slot_valid
);

  localparam int TW = $clog2(TIME_LIMIT_S + 1);
  localparam int OW = (OVERLAP_S > 1) ? $clog2(OVERLAP_S) : 1;
  localparam int SW = CNT_W + 1;

  typedef enum logic [1:0] {S_RUN, S_WAIT, S_OVL} st_t;

  st_t             state;
  logic [TW-1:0]   sec_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic [TO_W-1:0] wait_cnt;
  logic [OW-1:0]   ovl_cnt;

  logic [SW-1:0]   byte_sum;
  logic            limit_hit, swap, ovl_done;

  assign byte_sum  = {1'b0, byte_cnt} + (pkt_valid ? SW'(pkt_bytes) : SW'(0));
  assign limit_hit = (sec_cnt == TW'(TIME_LIMIT_S)) || (byte_cnt >= CNT_W'(BYTE_LIMIT));
  assign swap      = (state == S_WAIT) && rekey_ready;
  assign ovl_done  = (state == S_OVL) && sec_tick && (ovl_cnt == OW'(OVERLAP_S - 1));

  assign rekey_req   = (state == S_WAIT) && (wait_cnt == '0);
  assign timeout_err = (state == S_WAIT) && !rekey_ready && (wait_cnt == ack_timeout);
  assign zeroize_old = ovl_done;
  assign slot_valid  = (state == S_OVL) ? 2'b11 : (epoch ? 2'b10 : 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_RUN;
      epoch    <= 1'b0;
      wait_cnt <= '0;
      ovl_cnt  <= '0;
    end else begin
      case (state)
        S_RUN: begin
          if (limit_hit) begin
            state    <= S_WAIT;
            wait_cnt <= '0;
          end
        end
        S_WAIT: begin
          if (rekey_ready) begin
            state   <= S_OVL;
            epoch   <= ~epoch;
            ovl_cnt <= '0;
          end else if (timeout_err) begin
            wait_cnt <= '0;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        S_OVL: begin
          if (ovl_done)      state   <= S_RUN;
          else if (sec_tick) ovl_cnt <= ovl_cnt + 1'b1;
        end
        default: state <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_cnt  <= '0;
      byte_cnt <= '0;
    end else if (swap) begin
      sec_cnt  <= TW'(sec_tick);
      byte_cnt <= pkt_valid ? CNT_W'(pkt_bytes) : '0;
    end else begin
      if (sec_tick && sec_cnt != TW'(TIME_LIMIT_S)) sec_cnt <= sec_cnt + 1'b1;
      byte_cnt <= byte_sum[CNT_W] ? '1 : byte_sum[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/key_rotation_ctrl_chk.sv
module key_rotation_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rekey_req,
  input logic       timeout_err,
  input logic       zeroize_old,
  input logic       epoch,
  input logic [1:0] slot_valid
);

  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rekey_req |=> !rekey_req);

  assert_cur_slot_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid[epoch]);

  assert_swap_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (epoch != $past(epoch)) |-> (slot_valid == 2'b11));

  assert_zeroize_retires_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zeroize_old |=> ($countones(slot_valid) == 1) && !zeroize_old);

  assert_no_req_in_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rekey_req |-> ($countones(slot_valid) == 1) && !zeroize_old);

  assert_timeout_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> rekey_req);

endmodule

bind key_rotation_ctrl key_rotation_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rekey_req(rekey_req), .timeout_err(timeout_err),
  .zeroize_old(zeroize_old), .epoch(epoch), .slot_valid(slot_valid)
);

// File: tb/key_rotation_ctrl_tb.sv
module key_rotation_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [15:0] pkt_bytes = '0;
  logic [15:0] ack_timeout = 16'd2;
  logic        rekey_ready = 1'b0;
  logic        rekey_req, timeout_err, zeroize_old, epoch;
  logic [1:0]  slot_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  key_rotation_ctrl #(
    .TIME_LIMIT_S(3), .OVERLAP_S(2), .CNT_W(32), .BYTE_LIMIT(64'd1000),
    .LEN_W(16), .TO_W(16)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .pkt_valid(pkt_valid),
    .pkt_bytes(pkt_bytes), .ack_timeout(ack_timeout), .rekey_ready(rekey_ready),
    .rekey_req(rekey_req), .timeout_err(timeout_err), .zeroize_old(zeroize_old),
    .epoch(epoch), .slot_valid(slot_valid)
  );

  // row: {tick, pkt_valid, bytes[15:0], ready, exp req, err, zeroize, epoch, slots[1:0]}
  localparam int NV = 17;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01}, // R2 seconds
    {1'b1, 1'b0, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01},
    {1'b1, 1'b0, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01},
    {1'b0, 1'b0, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01},
    {1'b0, 1'b0, 16'd0,   1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01}, // R2 R10 request
    {1'b0, 1'b0, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01},
    {1'b0, 1'b0, 16'd0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01}, // R8 timeout
    {1'b0, 1'b0, 16'd0,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01}, // R8 retry, ready
    {1'b1, 1'b1, 16'd600, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11}, // R5 overlap
    {1'b1, 1'b0, 16'd0,   1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11}, // R7 zeroize
    {1'b0, 1'b1, 16'd300, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10}, // R7 retired, R9 stray ready
    {1'b0, 1'b1, 16'd100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10}, // R9 epoch unchanged
    {1'b1, 1'b0, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10},
    {1'b0, 1'b0, 16'd0,   1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10}, // R3 volume request
    {1'b1, 1'b0, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11}, // R5 second swap
    {1'b1, 1'b0, 16'd0,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b11}, // R7
    {1'b0, 1'b0, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01}  // R6 counts restarted
  };

  task automatic step(input logic tk, input logic pv, input logic [15:0] by,
                      input logic rd, input logic [5:0] exp, input string tag);
    logic [5:0] act;
    @(negedge clk);
    sec_tick = tk; pkt_valid = pv; pkt_bytes = by; rekey_ready = rd;
    #1;
    act = {rekey_req, timeout_err, zeroize_old, epoch, slot_valid};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {req,err,zero,epoch,slots} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    step(0, 0, 0, 0, 6'b000001, "R1 reset state");
    rst_n = 1'b1;
    step(0, 0, 0, 0, 6'b000001, "R1 after release");

    for (int i = 0; i < NV; i++)
      step(VEC[i][24], VEC[i][23], VEC[i][22:7], VEC[i][6], VEC[i][5:0],
           $sformatf("R2/R3/R5/R7/R8/R9 table row %0d", i));

    ack_timeout = 16'd4;
    step(1, 0, 0,     0, 6'b000001, "R2 third second");
    step(0, 1, 2000,  0, 6'b000001, "R2 limit seen");
    step(0, 1, 2000,  0, 6'b100001, "R10 request pulse");
    step(0, 0, 0,     0, 6'b000001, "R4 byte limit ignored while waiting");
    step(0, 0, 0,     0, 6'b000001, "R4 wait 2");
    step(0, 0, 0,     0, 6'b000001, "R4 wait 3");
    step(0, 0, 0,     0, 6'b010001, "R8 timeout after 4 cycles");
    step(0, 0, 0,     1, 6'b100001, "R8 retry request");
    step(1, 1, 1000,  0, 6'b000111, "R4 byte limit ignored in overlap");
    step(1, 0, 0,     0, 6'b001111, "R7 zeroize on last second");
    step(0, 0, 0,     0, 6'b000110, "R6 limit reached from overlap traffic");
    step(0, 0, 0,     1, 6'b100110, "R6 request after overlap");
    step(0, 0, 0,     0, 6'b000011, "R5 swap back to slot 0");

    @(negedge clk);
    rst_n = 1'b0;
    step(0, 0, 0, 0, 6'b000001, "R1 reset during overlap");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule